// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a card's reply on the reader side of a short-range link. The card answers by switching a 212 kHz subcarrier on or off for each bit. An analog front end with hysteresis turns that subcarrier into a logic input that toggles rapidly while a one is being sent and stays quiet while a zero is being sent. The receiver does not try to lock onto the subcarrier. It opens a series of fixed-length bit windows, counts the level changes seen in each window, and decides each bit from that count.

All timing is taken from one reference point. The transmitter pulses `start` when its own frame ends, and that pulse restarts the receiver's tick timer. One tick is `CLK_DIV` system clocks. After a fixed delay the first window opens, and the remaining windows follow it with no gap. The reply carries no start, stop or length marks, so the caller gives the bit count with the start pulse. For the same reason, a reply of all zeros cannot be told apart from no card at all. The decoded bits are packed into a word with the first bit in bit 0, and a one-clock `done` strobe marks the moment the word is ready.

The input passes through a two-flop synchronizer before any edge is detected.

Top module: `rxec_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done` is 0 and `data_out` is all zeros.
- R2: A tick is `CLK_DIV` clocks, counted from the clock edge that samples `start`. Window 0 opens when the tick count reaches `START_DELAY` (default 490).
- R3: Each window lasts `WIN_LEN` ticks (default 150), and each window begins exactly where the one before it ends. Every input level change inside a window adds one to that window's count, and the count is cleared when each window opens. Changes seen before window 0 opens do not affect any bit.
- R4: A window whose count is strictly greater than `CNT_LO` (20) and strictly less than `CNT_HI` (60) decodes as 1. Any other count decodes as 0, so 20 gives 0, 21 gives 1, 59 gives 1 and 60 gives 0.
- R5: The edge counter saturates at 2^`CNT_W`-1 (255 by default) and never wraps. A window with 300 changes therefore decodes as 0.
- R6: The bit from window k is placed in `data_out[k]`. Bits at or above the requested count are 0.
- R7: `done` is high for exactly one clock, in the cycle after the clock edge at which the tick count reaches `START_DELAY + WIN_LEN*N`. `data_out` takes its new value in that same cycle and holds it until the next `done`.
- R8: `num_bits` is captured on `start` and clamped to `MAX_BITS`. A request of 0 bits raises `done` in the cycle after `start`, with `data_out` equal to 0.
- R9: A `start` pulse while a reception is in progress restarts the timing and drops the earlier frame. No `done` is raised for the dropped frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock pulse at the transmitter's frame end; restarts the reference timer |
| num_bits | input | NB_W | Number of reply bits to receive, captured on `start` |
| rx_in | input | 1 | Asynchronous hysteresis-thresholded subcarrier input |
| data_out | output | MAX_BITS | Received word, first bit in bit 0 |
| done | output | 1 | One-clock strobe when `data_out` holds a new word |

## Verification
The assertions assume that `start` is not raised on two clocks in a row with a zero bit count. They also assume that every level held on `rx_in` lasts at least one clock, so the synchronizer sees each change. The stimulus meets both conditions: it drives `rx_in` only on falling clock edges, and it uses one-clock start pulses spaced far apart. It places each group of toggles inside its window, with a margin from both window edges that is larger than the synchronizer delay. That way the count of every window is exact, while the `done` cycle is still checked against the full timer arithmetic.

// File: rtl/rxec_pkg.sv
package rxec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2
  } rx_state_t;
endpackage

// File: rtl/rxec_sync.sv
module rxec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  // chain[STAGES-1] is the synchronized level; chain[STAGES] its history
  assign edge_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/rxec_timer.sv
module rxec_timer
  import rxec_pkg::*;
#(
  parameter int CLK_DIV     = 32,
  parameter int START_DELAY = 490,
  parameter int WIN_LEN     = 150,
  parameter int MAX_BITS    = 16,
  localparam int NB_W   = $clog2(MAX_BITS + 1),
  localparam int IDX_W  = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1,
  localparam int PRE_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int TMAX   = (START_DELAY > WIN_LEN) ? START_DELAY : WIN_LEN,
  localparam int TCNT_W = $clog2(TMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NB_W-1:0]  num_bits,
  output logic             win_open,
  output logic             win_start,
  output logic             win_end,
  output logic             last_win,
  output logic             zero_len,
  output logic [IDX_W-1:0] bit_idx,
  output logic [NB_W-1:0]  n_lat
);
  rx_state_t          st;
  logic [PRE_W-1:0]   pre;
  logic [TCNT_W-1:0]  tcnt;
  logic               tick;
  logic [NB_W-1:0]    n_clamp;

  assign n_clamp  = (num_bits > NB_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : num_bits;
  assign zero_len = start && (n_clamp == '0);
  assign tick     = (pre == PRE_W'(CLK_DIV - 1));

  assign win_open  = (st == ST_RECV);
  assign win_start = !start && (st == ST_WAIT) && tick &&
                     (tcnt == TCNT_W'(START_DELAY - 1));
  assign win_end   = !start && (st == ST_RECV) && tick &&
                     (tcnt == TCNT_W'(WIN_LEN - 1));
  assign last_win  = win_end && ((NB_W'(bit_idx) + 1'b1) == n_lat);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
    end else if (start || tick) begin
      pre <= '0;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      tcnt    <= '0;
      bit_idx <= '0;
      n_lat   <= '0;
    end else if (start) begin
      st      <= (n_clamp == '0) ? ST_IDLE : ST_WAIT;
      tcnt    <= '0;
      bit_idx <= '0;
      n_lat   <= n_clamp;
    end else if (tick) begin
      case (st)
        ST_WAIT: begin
          if (win_start) begin
            st   <= ST_RECV;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_RECV: begin
          if (win_end) begin
            tcnt    <= '0;
            bit_idx <= bit_idx + 1'b1;
            if (last_win) st <= ST_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          tcnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rxec_edgecnt.sv
module rxec_edgecnt #(
  parameter int CNT_W  = 8,
  parameter int CNT_LO = 20,
  parameter int CNT_HI = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             close,
  input  logic             en,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt,
  output logic             bit_o
);
  logic [CNT_W-1:0] nxt;
  logic             inc;

  assign inc   = en && edge_i;
  assign nxt   = (inc && (cnt != {CNT_W{1'b1}})) ? cnt + 1'b1 : cnt;
  assign bit_o = (nxt > CNT_W'(CNT_LO)) && (nxt < CNT_W'(CNT_HI));

  always_ff @(posedge clk) begin
    if (rst || clr || close) cnt <= '0;
    else                     cnt <= nxt;
  end
endmodule

// File: rtl/rxec_top.sv
module rxec_top
  import rxec_pkg::*;
#(
  parameter int CLK_DIV     = 32,
  parameter int START_DELAY = 490,
  parameter int WIN_LEN     = 150,
  parameter int MAX_BITS    = 16,
  parameter int CNT_W       = 8,
  parameter int CNT_LO      = 20,
  parameter int CNT_HI      = 60,
  parameter int SYNC_STAGES = 2,
  localparam int NB_W  = $clog2(MAX_BITS + 1),
  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NB_W-1:0]     num_bits,
  input  logic                rx_in,
  output logic [MAX_BITS-1:0] data_out,
  output logic                done
);
  logic             rx_edge;
  logic             win_open, win_start, win_end, last_win, zero_len;
  logic [IDX_W-1:0] bit_idx;
  logic [NB_W-1:0]  n_lat;
  logic [CNT_W-1:0] cnt;
  logic             win_bit;
  logic [MAX_BITS-1:0] acc;
  logic [MAX_BITS-1:0] bit_mask;

  rxec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (rx_in),
    .edge_o (rx_edge)
  );

  rxec_timer #(
    .CLK_DIV     (CLK_DIV),
    .START_DELAY (START_DELAY),
    .WIN_LEN     (WIN_LEN),
    .MAX_BITS    (MAX_BITS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .num_bits  (num_bits),
    .win_open  (win_open),
    .win_start (win_start),
    .win_end   (win_end),
    .last_win  (last_win),
    .zero_len  (zero_len),
    .bit_idx   (bit_idx),
    .n_lat     (n_lat)
  );

  rxec_edgecnt #(
    .CNT_W  (CNT_W),
    .CNT_LO (CNT_LO),
    .CNT_HI (CNT_HI)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (win_start || start),
    .close  (win_end),
    .en     (win_open && !start),
    .edge_i (rx_edge),
    .cnt    (cnt),
    .bit_o  (win_bit)
  );

  assign bit_mask = MAX_BITS'(1) << bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      data_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (zero_len) begin
        acc      <= '0;
        data_out <= '0;
        done     <= 1'b1;
      end else if (start) begin
        acc <= '0;
      end else if (win_end) begin
        if (win_bit) acc <= acc | bit_mask;
        if (last_win) begin
          data_out <= win_bit ? (acc | bit_mask) : acc;
          done     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxec_chk.sv
module rxec_chk #(
  parameter int MAX_BITS = 16,
  parameter int CNT_W    = 8,
  parameter int NB_W     = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [NB_W-1:0]     num_bits,
  input logic [MAX_BITS-1:0] data_out,
  input logic                done,
  input logic [NB_W-1:0]     n_lat,
  input logic [CNT_W-1:0]    cnt,
  input logic                cnt_en,
  input logic                cnt_clr,
  input logic                rx_edge
);
  // R1: reset forces a quiet output
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!done && data_out == '0));

  // R7: done is a single-clock pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  // R7: the word only moves when done is raised
  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(data_out));

  // R6: no bit set at or above the requested count
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> ((data_out >> n_lat) == '0));

  // R5: a full counter stays full
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt == {CNT_W{1'b1}} && cnt_en && rx_edge && !cnt_clr) |=> (cnt == {CNT_W{1'b1}}));

  // R8: an empty request finishes at once
  p_zero_len_r8: assert property (@(posedge clk) disable iff (rst)
    (start && num_bits == '0) |=> (done && data_out == '0));

  // R9: a restart never completes on the next clock
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (start && num_bits != '0) |=> !done);
endmodule

bind rxec_top rxec_chk #(
  .MAX_BITS (MAX_BITS),
  .CNT_W    (CNT_W),
  .NB_W     (NB_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .num_bits (num_bits),
  .data_out (data_out),
  .done     (done),
  .n_lat    (n_lat),
  .cnt      (cnt),
  .cnt_en   (win_open && !start),
  .cnt_clr  (win_start || win_end || start),
  .rx_edge  (rx_edge)
);

// File: tb/sim_rxec_top.sv
module sim_rxec_top;
  localparam int DIV  = 4;
  localparam int SD   = 490;
  localparam int WL   = 150;
  localparam int MAXB = 16;
  localparam int NBW  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rx = 1'b0;
  logic [NBW-1:0] nb = '0;
  wire  [MAXB-1:0] dout;
  wire  done;

  always #2 clk = ~clk;

  rxec_top #(.CLK_DIV(DIV), .START_DELAY(SD), .WIN_LEN(WL), .MAX_BITS(MAXB)) u0 (
    .clk(clk), .rst(rst), .start(start), .num_bits(nb), .rx_in(rx),
    .data_out(dout), .done(done)
  );

  int tests = 0;
  int fails = 0;
  int done_seen = 0;
  int cnts [0:16];
  longint cyc = 0;
  longint s_cyc = 0;
  longint done_at = 0;
  bit pend = 0;
  bit exp_done = 0;
  logic [MAXB-1:0] exp_next = '0;
  logic [MAXB-1:0] frame_exp = '0;
  logic [MAXB-1:0] exp_data = '0;

  function automatic int eff_n(int n);
    return (n > MAXB) ? MAXB : n;
  endfunction

  function automatic bit dec(int e);
    int c;
    c = (e > 255) ? 255 : e;
    return (c > 20) && (c < 60);
  endfunction

  function automatic logic [MAXB-1:0] word_of(int n);
    logic [MAXB-1:0] w;
    w = '0;
    for (int k = 0; k < eff_n(n); k++) w[k] = dec(cnts[k]);
    return w;
  endfunction

  // Reference model: timer arithmetic from R2, R3, R7, R8, R9
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      pend = 0; exp_done = 0; exp_data = '0;
    end else begin
      if (start) begin
        s_cyc = cyc;
        if (eff_n(int'(nb)) == 0) done_at = cyc;
        else done_at = cyc + longint'(SD + WL * eff_n(int'(nb))) * DIV;
        pend = 1;
        frame_exp = exp_next;
      end
      exp_done = pend && (cyc == done_at);
      if (exp_done) begin
        exp_data = frame_exp;
        pend = 0;
      end
    end
  end

  // Per-clock comparison against the model (R7)
  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if (done !== exp_done || dout !== exp_data) begin
        fails++;
        if (fails < 12)
          $display("FAIL R7 cycle %0d: done=%b data=%h, expected done=%b data=%h",
                   cyc, done, dout, exp_done, exp_data);
      end
      if (done === 1'b1) done_seen++;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic toggles_at(longint at, int e);
    while (cyc < at) @(negedge clk);
    repeat (e) begin
      @(negedge clk);
      rx = ~rx;
    end
  endtask

  task automatic toggle_win(int k, int e);
    toggles_at(s_cyc + longint'(SD + WL * k) * DIV + 8, e);
  endtask

  task automatic kick(int n);
    exp_next = word_of(n);
    @(negedge clk);
    start = 1'b1;
    nb = NBW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drive_wins(int nw);
    for (int k = 0; k < nw; k++) toggle_win(k, cnts[k]);
  endtask

  task automatic finish(string tag, int n);
    while (cyc < done_at + 3) @(negedge clk);
    chk(tag, longint'(dout), longint'(word_of(n)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk("R1 done in reset", longint'(done), 0);
    chk("R1 data in reset", longint'(dout), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 data after reset", longint'(dout), 0);

    // R2 R4 R6: mixed pattern, first bit in bit 0
    cnts = '{42, 0, 42, 42, 0, 0, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    base = done_seen;
    kick(8); drive_wins(8); finish("R6 mixed word", 8);
    chk("R2 one done per frame", longint'(done_seen - base), 1);

    // R4: threshold boundaries 20, 21, 59, 60
    cnts = '{20, 21, 59, 60, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    kick(4); drive_wins(4); finish("R4 thresholds", 4);
    chk("R4 expected code", longint'(dout), 4'b0110);

    // R5: 300 edges saturate to 0 decision, 44 edges give 1
    cnts = '{300, 44, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    kick(2); drive_wins(2); finish("R5 saturation", 2);
    chk("R5 expected code", longint'(dout), 2'b10);

    // R3: toggling during the start delay is ignored
    cnts = '{0, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    kick(3);
    toggles_at(s_cyc + 100, 42);
    drive_wins(3); finish("R3 pre-window ignored", 3);
    chk("R3 expected code", longint'(dout), 3'b010);

    // R8: empty request
    base = done_seen;
    kick(0); finish("R8 zero bits word", 0);
    chk("R8 zero bits done", longint'(done_seen - base), 1);

    // R8: request above MAX_BITS is clamped
    for (int k = 0; k < 17; k++) cnts[k] = (k % 3 == 0) ? 0 : 42;
    base = done_seen;
    kick(20); drive_wins(16); finish("R8 clamp word", 20);
    toggle_win(16, 42);
    repeat (WL * DIV) @(negedge clk);
    chk("R8 clamp single done", longint'(done_seen - base), 1);
    chk("R8 clamp word held", longint'(dout), longint'(word_of(16)));

    // R9: restart mid-frame drops the earlier frame
    for (int k = 0; k < 17; k++) cnts[k] = 42;
    base = done_seen;
    kick(4); drive_wins(2);
    cnts = '{42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    kick(2); drive_wins(2); finish("R9 restart word", 2);
    chk("R9 single done", longint'(done_seen - base), 1);

    // R6: all-zero reply
    cnts = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    kick(5); drive_wins(5); finish("R6 all zero", 5);

    summary();
    $finish;
  end
endmodule